// File: doc/BRIEF.md
# Dual-Mode Sampling Strobe Sequencer

This block produces the sample-and-hold strobes for a column driver in which each output group captures three colour channels. A start edge, taken from one end of the column, loads a single token into a chain of groups. Every rising edge of the first shift clock moves the token one group further. The group that holds the token raises its channel strobes. When the token leaves the far end, the block emits a one-cycle carry so that a second driver can continue the sweep.

In stripe mode one shift clock is used, and all three channels of the active group strobe together. In sequential mode (used for delta or mosaic pixel layouts) a three-phase clock is applied, and each channel strobes during its own phase. The sequencer does nothing until it has been armed. A reset pulse on `line_rst` that is at least three cycles wide disarms it. An inhibit pulse that is at least five cycles wide clears the chain and arms it. Every input, the three shift clocks included, is sampled on the system clock `clk`.

Top module: `sample_strobe_seq`

## Requirements
- R1: With `mode`=0, all three strobes of the group holding the token (bits 3g, 3g+1 and 3g+2 of `strobe` for group g) are high together. `ck[1]` and `ck[2]` have no effect on any output.
- R2: With `mode`=1, strobe bit 3g+c of the active group g is high exactly in the cycles after a cycle in which `ck[c]` was sampled high, for c = 0, 1, 2.
- R3: Each rising edge of `ck[0]` seen at a clock edge moves the token one group further. A pending start loads the token into the entry group on the first such edge after the start edge. At most one group ever holds the token.
- R4: `inh` sampled high on five or more consecutive edges clears the chain and arms the block. A run of four or fewer has no effect.
- R5: After `rst_n` is released, and after an accepted line reset, `strobe` stays zero until the block is armed.
- R6: `line_rst` sampled high on three or more consecutive edges clears the chain and disarms the block. A run of two or fewer has no effect.
- R7: Only the rising edge of the selected start input counts, so holding it high does not move the first strobe. A start edge is ignored while a start is pending, while the chain holds a token, and while the block is inhibited or not armed.
- R8: With `dir`=0, `start_l` is used and the token enters group 0 and moves upward. With `dir`=1, `start_r` is used and the token enters group GROUPS-1 and moves downward. The start input that is not selected is ignored.
- R9: `carry` is high for exactly one cycle: the cycle after a `ck[0]` rising edge moves the token out of the last group. In that cycle the chain is empty.
- R10: While `inh` is high, every strobe bit is low. The token still advances on `ck[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset (chain empty, disarmed) |
| line_rst | input | 1 | Line reset pulse, qualified by width (3 cycles) |
| inh | input | 1 | Inhibit; masks strobes, and a pulse of 5 or more cycles clears and arms |
| dir | input | 1 | 0: enter at group 0 via start_l; 1: enter at last group via start_r |
| mode | input | 1 | 0: stripe (ganged channels); 1: sequential three-phase |
| start_l | input | 1 | Start input at the low end |
| start_r | input | 1 | Start input at the high end |
| ck | input | 3 | Shift clocks; ck[0] advances the chain, ck[2:1] are phases in mode 1 |
| strobe | output | 3*GROUPS | Channel strobes, bit 3g+c is channel c of group g |
| carry | output | 1 | One-cycle pulse when the token leaves the far end |

## Verification
Two functions can fall in the same cycle: the last group shifting out, which raises `carry`, and a new start edge. The bench raises `start_l` on the same edge as the `ck[0]` rising edge that empties the chain. Because the chain is still occupied at that edge, the start must be dropped. The cycle-accurate reference model predicts this, so no second sweep may appear. A stretched start pulse and a short inhibit pulse arriving in the middle of a sweep are also provoked, and `strobe` and `carry` are compared against the model on every cycle.

// File: rtl/sample_strobe_seq.sv
module sample_strobe_seq #(
  parameter int GROUPS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_rst,
  input  logic                  inh,
  input  logic                  dir,
  input  logic                  mode,
  input  logic                  start_l,
  input  logic                  start_r,
  input  logic [2:0]            ck,
  output logic [3*GROUPS-1:0]   strobe,
  output logic                  carry
);
  localparam int NCH = 3;

  logic [GROUPS-1:0] tok;
  logic [2:0]        ckq;
  logic              sel_q, pend, armed;
  logic [1:0]        rcnt;
  logic [2:0]        icnt;

  wire sel     = dir ? start_r : start_l;
  wire adv     = ck[0] & ~ckq[0];
  wire rst_ok  = line_rst & (rcnt >= 2'd2);
  wire inh_ok  = inh & (icnt >= 3'd4);
  wire at_end  = dir ? tok[0] : tok[GROUPS-1];
  wire launch  = sel & ~sel_q & armed & ~inh & ~pend & ~(|tok);

  wire [GROUPS-1:0] shifted = dir ? {1'b0, tok[GROUPS-1:1]} : {tok[GROUPS-2:0], 1'b0};
  wire [GROUPS-1:0] entry   = dir ? {1'b1, {(GROUPS-1){1'b0}}} : {{(GROUPS-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok   <= '0;
      ckq   <= '0;
      sel_q <= 1'b0;
      pend  <= 1'b0;
      armed <= 1'b0;
      carry <= 1'b0;
      rcnt  <= '0;
      icnt  <= '0;
    end else begin
      ckq   <= ck;
      sel_q <= sel;
      rcnt  <= line_rst ? ((rcnt == 2'd3) ? rcnt : rcnt + 2'd1) : 2'd0;
      icnt  <= inh ? ((icnt == 3'd7) ? icnt : icnt + 3'd1) : 3'd0;
      if (rst_ok) begin
        tok   <= '0;
        pend  <= 1'b0;
        armed <= 1'b0;
        carry <= 1'b0;
      end else if (inh_ok) begin
        tok   <= '0;
        pend  <= 1'b0;
        armed <= 1'b1;
        carry <= 1'b0;
      end else begin
        carry <= adv & at_end;
        if (adv) tok <= pend ? entry : shifted;
        if (adv && pend) pend <= 1'b0;
        else if (launch) pend <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign strobe[NCH*g+c] = tok[g] & ~inh & (~mode | ckq[c]);
    end
    AST_STRIPE_GANG: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |-> (strobe[NCH*g] == strobe[NCH*g+1]) && (strobe[NCH*g] == strobe[NCH*g+2])); // R1
  end

  AST_ONE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok)); // R3
  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> strobe == '0); // R5
  AST_ARM_NEEDS_INH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(inh,1) && $past(inh,2) && $past(inh,3) && $past(inh,4) && $past(inh,5)); // R4
  AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> !carry); // R9
  AST_CARRY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> tok == '0); // R9
endmodule

// File: tb/sample_strobe_seq_test.sv
module sample_strobe_seq_test;
  localparam int G = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, line_rst = 1'b0, inh = 1'b0, dir = 1'b0, mode = 1'b0;
  logic start_l = 1'b0, start_r = 1'b0;
  logic [2:0] ck = 3'b000;
  logic [3*G-1:0] strobe;
  logic carry;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R5";

  sample_strobe_seq #(.GROUPS(G)) uut (
    .clk(clk), .rst_n(rst_n), .line_rst(line_rst), .inh(inh), .dir(dir), .mode(mode),
    .start_l(start_l), .start_r(start_r), .ck(ck), .strobe(strobe), .carry(carry));

  always #5 clk = ~clk;

  int mpos = -1, mrc = 0, mic = 0;
  bit mpend = 0, marmed = 0, mcarry = 0, msel = 0;
  bit [2:0] mck = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mpos = -1; mrc = 0; mic = 0; mpend = 0; marmed = 0; mcarry = 0; msel = 0; mck = 0;
    end else begin
      bit s, rise, adv, rok, iok, req;
      int last, first;
      s = dir ? start_r : start_l;
      rise = s && !msel;
      adv = ck[0] && !mck[0];
      rok = line_rst && mrc >= 2;
      iok = inh && mic >= 4;
      last = dir ? 0 : G - 1;
      first = dir ? G - 1 : 0;
      if (rok) begin
        mpos = -1; mpend = 0; marmed = 0; mcarry = 0;
      end else if (iok) begin
        mpos = -1; mpend = 0; marmed = 1; mcarry = 0;
      end else begin
        req = rise && marmed && !inh && !mpend && mpos < 0;
        mcarry = adv && mpos == last;
        if (adv) begin
          if (mpend) begin mpos = first; mpend = 0; end
          else if (mpos >= 0) mpos = (mpos == last) ? -1 : mpos + (dir ? -1 : 1);
        end
        if (req) mpend = 1;
      end
      mck = ck; msel = s;
      mrc = line_rst ? (mrc < 3 ? mrc + 1 : 3) : 0;
      mic = inh ? (mic < 7 ? mic + 1 : 7) : 0;
    end
  end

  always @(negedge clk) begin
    logic [3*G-1:0] exp;
    for (int i = 0; i < 3*G; i++)
      exp[i] = (mpos == i/3) && !inh && (!mode || mck[i%3]);
    total++;
    if (strobe !== exp) begin
      bad++;
      $display("FAIL %s strobe=%h expected=%h", tag, strobe, exp);
    end
    total++;
    if (carry !== mcarry) begin
      bad++;
      $display("FAIL R9 carry=%b expected=%b", carry, mcarry);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog total=%0d expected finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_stripe(bit noise);
    ck = noise ? 3'b111 : 3'b001; cyc(2);
    ck = noise ? 3'b110 : 3'b000; cyc(2);
  endtask

  task automatic shift_delta();
    ck = 3'b001; cyc(2);
    ck = 3'b010; cyc(2);
    ck = 3'b100; cyc(2);
    ck = 3'b000; cyc(1);
  endtask

  task automatic pulse_start(bit right, int width);
    if (right) start_r = 1'b1; else start_l = 1'b1;
    cyc(width);
    start_r = 1'b0; start_l = 1'b0;
  endtask

  task automatic pulse_inh(int width);
    inh = 1'b1; cyc(width); inh = 1'b0; cyc(1);
  endtask

  initial begin
    tag = "R5"; cyc(3); rst_n = 1'b1; cyc(2);
    pulse_start(0, 1);
    for (int k = 0; k < 4; k++) shift_stripe(0);

    tag = "R4"; pulse_inh(4);
    pulse_start(0, 1);
    for (int k = 0; k < 4; k++) shift_stripe(0);
    pulse_inh(5);

    tag = "R1"; pulse_start(0, 1);
    for (int k = 0; k < G + 2; k++) shift_stripe(1);

    tag = "R7"; start_l = 1'b1; cyc(3);
    for (int k = 0; k < 3; k++) shift_stripe(0);
    start_l = 1'b0;
    pulse_start(0, 1);
    for (int k = 0; k < G; k++) shift_stripe(0);

    tag = "R2"; mode = 1'b1; pulse_start(0, 1);
    for (int k = 0; k < G + 1; k++) shift_delta();

    tag = "R8"; mode = 1'b0; dir = 1'b1; cyc(1);
    pulse_start(0, 1);
    shift_stripe(0);
    pulse_start(1, 1);
    for (int k = 0; k < G + 1; k++) shift_stripe(0);

    tag = "R10"; dir = 1'b0; cyc(1); pulse_start(0, 1);
    for (int k = 0; k < G + 1; k++) begin
      if (k == 3) inh = 1'b1;
      shift_stripe(0);
      inh = 1'b0;
    end

    tag = "R3"; pulse_start(0, 1);
    for (int k = 0; k < G + 1; k++) begin
      if (mpos == G - 1) start_l = 1'b1;
      shift_stripe(0);
      start_l = 1'b0;
    end
    for (int k = 0; k < 3; k++) shift_stripe(0);

    tag = "R6"; pulse_start(0, 1); shift_stripe(0);
    line_rst = 1'b1; cyc(2); line_rst = 1'b0;
    for (int k = 0; k < 2; k++) shift_stripe(0);
    line_rst = 1'b1; cyc(3); line_rst = 1'b0;
    pulse_start(0, 1);
    for (int k = 0; k < 3; k++) shift_stripe(0);
    pulse_inh(6);
    pulse_start(0, 1);
    for (int k = 0; k < G + 1; k++) shift_stripe(0);

    cyc(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule